// File: doc/BRIEF.md
# Phase-Accumulating Waveform Synthesizer

This core is a numerically controlled oscillator. On every master-clock edge it adds a 28-bit tuning word to a 28-bit phase register and adds a 12-bit phase offset to the result. The phase is then shaped into one of three waveforms. The first is a sine built from a quarter-wave amplitude table. The second is a linear up-down ramp taken from the upper phase bits. The third is a square wave on a separate pin, taken from the top phase bit either directly or after a toggle that halves its rate. The output frequency is `f_clk * ftw / 2^28`.

A soft restart input clears only the running phase and parks the 10-bit amplitude word at midscale. The tuning word, offset and mode inputs keep whatever values they have, so the waveform restarts cleanly from phase zero a fixed time after the restart is released. A freeze input stops the whole datapath in place. Settings can still change while frozen, and they take effect on the first edge after release. A separate power-down input forces the amplitude word to zero. One combination of the mode inputs is reserved. That combination parks the output at midscale and raises a flag.

Top module: `dds_core`

## Requirements
- R1: On each clock edge where `core_reset` and `freeze` are both 0, the phase register advances by `ftw` modulo 2^28. Wrap-around and `ftw`=0 are both legal.
- R2: On each edge where `core_reset` is 1, the phase register is cleared, `dac_word` becomes 512 (midscale) and `sq_out` becomes 0. `ftw`, `phase_ofs` and the mode inputs are left untouched.
- R3: Count the edges where `core_reset` is 0 and `freeze` is 0, starting from the edge that releases the restart. After edges 1 to 7, `dac_word` stays at 512. After edge k (k ≥ 8), the sample shown uses phase (k−7)·`ftw` + `phase_ofs`·2^16.
- R4: After an edge where `freeze` is 1 (and `core_reset` is 0), `dac_word` and `sq_out` keep their previous values.
- R5: Mode and divide inputs that change while frozen take effect on the first edge after `freeze` returns to 0. The phase sequence continues from where it stopped.
- R6: While `dac_pd` is 1, `dac_word` reads 0 in the same cycle. When `dac_pd` returns to 0, the held sample shows again.
- R7: With `msb_out_en`=0 and `tri_mode`=0, `dac_word` is a sine. The upper 10 phase bits p select angle 2π(p+0.5)/1024. The value is 512+round(511·sin) for the positive half and 511+round(511·sin) for the negative half, within ±2 LSB.
- R8: With `msb_out_en`=0 and `tri_mode`=1, let t be the 11 phase bits [27:17]. `dac_word` is t when t < 1024 and 2047−t otherwise.
- R9: With `msb_out_en`=1, `tri_mode`=0 and `div2`=1, `sq_out` equals phase bit 27 of the current sample and `dac_word` carries the sine.
- R10: With `msb_out_en`=1, `tri_mode`=0 and `div2`=0, `sq_out` is a toggle. It starts at 0 at restart and flips on each sample where phase bit 27 rises (the first valid sample counts as rising if its bit 27 is 1).
- R11: With `msb_out_en`=1 and `tri_mode`=1 (reserved), `dac_word` is 512 and `sq_out` is 0 from the next sample. `rsv_flag` is 1 after every edge where that combination was present, and 0 otherwise.
- R12: `phase_ofs` is added as bits [27:16] of the phase before shaping, and it shifts every waveform by `phase_ofs`/4096 of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| core_reset | input | 1 | Soft restart: clears phase, output to midscale |
| freeze | input | 1 | Stops phase advance and holds outputs |
| dac_pd | input | 1 | Forces the amplitude word to zero |
| msb_out_en | input | 1 | Selects the square output family |
| tri_mode | input | 1 | Selects the ramp instead of the sine |
| div2 | input | 1 | 1: square at full rate, 0: square halved |
| ftw | input | 28 | Frequency tuning word |
| phase_ofs | input | 12 | Phase offset, upper phase bits |
| dac_word | output | 10 | Amplitude word |
| sq_out | output | 1 | Square output |
| rsv_flag | output | 1 | Reserved mode combination seen |

## Verification
The phase moves by one tuning word per running edge. That step is seen at the shaped outputs seven running edges later, so the first waveform sample appears after the eighth running edge following restart release. Mode, divide and reserved-flag changes act after a single edge. Power-down acts within the same cycle. The bench counts running edges itself, so a freeze stalls that count exactly as it stalls the datapath. It rebuilds each expected value from the sample index, the tuning word and the offset. It samples 2 ns after each rising edge, with all inputs changed only at that point.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    SHAPE_SINE   = 2'd0,
    SHAPE_RAMP   = 2'd1,
    SHAPE_SQUARE = 2'd2,
    SHAPE_RSVD   = 2'd3
  } shape_e;

  function automatic shape_e shape_decode(input logic msb_en, input logic ramp);
    case ({msb_en, ramp})
      2'b00:   return SHAPE_SINE;
      2'b01:   return SHAPE_RAMP;
      2'b10:   return SHAPE_SQUARE;
      default: return SHAPE_RSVD;
    endcase
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic [PW-1:0] ftw,
  output logic [PW-1:0] acc,
  output logic          acc_v,
  output logic          step
);
  assign step = !clr && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      acc_v <= 1'b0;
    end else if (clr) begin
      acc   <= '0;
      acc_v <= 1'b0;
    end else if (!hold) begin
      acc   <= acc + ftw;
      acc_v <= 1'b1;
    end
  end
endmodule

// File: rtl/dds_phase_pipe.sv
module dds_phase_pipe #(
  parameter int PW    = 28,
  parameter int OFS_W = 12,
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic [PW-1:0]    acc,
  input  logic             acc_v,
  input  logic [OFS_W-1:0] ofs,
  output logic [PW-1:0]    ph,
  output logic             ph_v
);
  localparam int PAD = PW - OFS_W;

  logic [PW-1:0]    ph_in [DEPTH];
  logic [PW-1:0]    ph_q  [DEPTH];
  logic [DEPTH-1:0] v_in;
  logic [DEPTH-1:0] v_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign ph_in[g] = acc + {ofs, {PAD{1'b0}}};
      assign v_in[g]  = acc_v;
    end else begin : g_body
      assign ph_in[g] = ph_q[g-1];
      assign v_in[g]  = v_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q[g] <= '0;
        v_q[g]  <= 1'b0;
      end else if (clr) begin
        v_q[g]  <= 1'b0;
      end else if (!hold) begin
        ph_q[g] <= ph_in[g];
        v_q[g]  <= v_in[g];
      end
    end
  end

  assign ph   = ph_q[DEPTH-1];
  assign ph_v = v_q[DEPTH-1];
endmodule

// File: rtl/dds_shaper.sv
module dds_shaper
  import dds_pkg::*;
#(
  parameter int PW     = 28,
  parameter int OW     = 10,
  parameter int SIN_AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic [PW-1:0] ph,
  input  logic          ph_v,
  input  logic          msb_en,
  input  logic          ramp,
  input  logic          div2,
  output logic [OW-1:0] dac_q,
  output logic          sq_q,
  output logic          out_v,
  output logic          rsv_q
);
  localparam int      QN  = 1 << SIN_AW;
  localparam int      AW  = OW - 1;
  localparam longint  AMP = (longint'(1) << AW) - 1;
  localparam logic [OW-1:0] MID = OW'(1) << AW;

  // Integer rational sine approximation, evaluated only with constant arguments
  function automatic logic [AW-1:0] amp_of(input int i);
    longint k, p, num, den;
    k   = 2 * longint'(i) + 1;
    p   = 4 * longint'(QN);
    num = AMP * 16 * k * (p - k);
    den = 5 * p * p - 4 * k * (p - k);
    return AW'((num + den / 2) / den);
  endfunction

  function automatic logic [OW-1:0] ramp_of(input logic [OW:0] t);
    return t[OW] ? ~t[OW-1:0] : t[OW-1:0];
  endfunction

  logic [AW-1:0] qtab [QN];
  for (genvar i = 0; i < QN; i++) begin : g_qtab
    assign qtab[i] = amp_of(i);
  end

  logic [1:0]        quad;
  logic [SIN_AW-1:0] idx;
  logic [SIN_AW-1:0] midx;
  logic [AW-1:0]     amp;
  logic [OW-1:0]     sine_w;
  logic [OW-1:0]     ramp_w;
  logic              msb_w;
  logic              rise_w;
  logic              half_q;
  logic              half_n;
  logic              msb_q;
  shape_e            sel;

  assign quad   = ph[PW-1 -: 2];
  assign idx    = ph[PW-3 -: SIN_AW];
  assign midx   = quad[0] ? ~idx : idx;
  assign amp    = qtab[midx];
  assign sine_w = quad[1] ? (MID - 1'b1 - OW'(amp)) : (MID + OW'(amp));
  assign ramp_w = ramp_of(ph[PW-1 -: OW+1]);
  assign msb_w  = ph[PW-1];
  assign rise_w = ph_v && msb_w && !msb_q;
  assign half_n = half_q ^ rise_w;
  assign sel    = shape_decode(msb_en, ramp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= MID;
      sq_q   <= 1'b0;
      out_v  <= 1'b0;
      msb_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (clr) begin
      dac_q  <= MID;
      sq_q   <= 1'b0;
      out_v  <= 1'b0;
      msb_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (!hold) begin
      out_v  <= ph_v;
      msb_q  <= ph_v && msb_w;
      half_q <= half_n;
      if (!ph_v) begin
        dac_q <= MID;
        sq_q  <= 1'b0;
      end else begin
        case (sel)
          SHAPE_SINE: begin
            dac_q <= sine_w;
            sq_q  <= 1'b0;
          end
          SHAPE_RAMP: begin
            dac_q <= ramp_w;
            sq_q  <= 1'b0;
          end
          SHAPE_SQUARE: begin
            dac_q <= sine_w;
            sq_q  <= div2 ? msb_w : half_n;
          end
          default: begin
            dac_q <= MID;
            sq_q  <= 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsv_q <= 1'b0;
    else        rsv_q <= (sel == SHAPE_RSVD);
  end
endmodule

// File: rtl/dds_core.sv
module dds_core #(
  parameter int PW      = 28,
  parameter int OW      = 10,
  parameter int OFS_W   = 12,
  parameter int SIN_AW  = 8,
  parameter int LATENCY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_reset,
  input  logic             freeze,
  input  logic             dac_pd,
  input  logic             msb_out_en,
  input  logic             tri_mode,
  input  logic             div2,
  input  logic [PW-1:0]    ftw,
  input  logic [OFS_W-1:0] phase_ofs,
  output logic [OW-1:0]    dac_word,
  output logic             sq_out,
  output logic             rsv_flag
);
  localparam int PIPE_DEPTH = LATENCY - 2;

  logic [PW-1:0] acc_val;
  logic          acc_v;
  logic          acc_adv;
  logic [PW-1:0] pipe_ph;
  logic          pipe_v;
  logic [OW-1:0] shp_dac;
  logic          shp_sq;
  logic          shp_valid;

  dds_phase_acc #(.PW(PW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (core_reset),
    .hold  (freeze),
    .ftw   (ftw),
    .acc   (acc_val),
    .acc_v (acc_v),
    .step  (acc_adv)
  );

  dds_phase_pipe #(.PW(PW), .OFS_W(OFS_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (core_reset),
    .hold  (freeze),
    .acc   (acc_val),
    .acc_v (acc_v),
    .ofs   (phase_ofs),
    .ph    (pipe_ph),
    .ph_v  (pipe_v)
  );

  dds_shaper #(.PW(PW), .OW(OW), .SIN_AW(SIN_AW)) u_shape (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (core_reset),
    .hold   (freeze),
    .ph     (pipe_ph),
    .ph_v   (pipe_v),
    .msb_en (msb_out_en),
    .ramp   (tri_mode),
    .div2   (div2),
    .dac_q  (shp_dac),
    .sq_q   (shp_sq),
    .out_v  (shp_valid),
    .rsv_q  (rsv_flag)
  );

  assign dac_word = dac_pd ? '0 : shp_dac;
  assign sq_out   = shp_sq;
endmodule

// File: rtl/dds_core_checker.sv
module dds_core_checker #(
  parameter int PW      = 28,
  parameter int OW      = 10,
  parameter int LATENCY = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_reset,
  input logic          freeze,
  input logic          msb_out_en,
  input logic          tri_mode,
  input logic [PW-1:0] ftw,
  input logic [PW-1:0] acc_val,
  input logic          acc_adv,
  input logic          shp_valid,
  input logic [OW-1:0] shp_dac,
  input logic          rsv_flag
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [OW-1:0] MID = OW'(1) << (OW - 1);

  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    run_cnt <= '0;
    else if (core_reset)                           run_cnt <= '0;
    else if (!freeze && run_cnt != CW'(LATENCY))   run_cnt <= run_cnt + 1'b1;
  end

  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_adv) |-> acc_val == $past(acc_val) + $past(ftw));

  a_r2_reset_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_reset) |-> (shp_dac == MID) && !shp_valid);

  a_r3_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt < CW'(LATENCY)) |-> !shp_valid);

  a_r3_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == CW'(LATENCY)) |-> shp_valid);

  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze) && !$past(core_reset)) |-> $stable(shp_dac));

  a_r11_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msb_out_en && tri_mode) |-> rsv_flag);
endmodule

bind dds_core dds_core_checker #(.PW(PW), .OW(OW), .LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_reset (core_reset),
  .freeze     (freeze),
  .msb_out_en (msb_out_en),
  .tri_mode   (tri_mode),
  .ftw        (ftw),
  .acc_val    (acc_val),
  .acc_adv    (acc_adv),
  .shp_valid  (shp_valid),
  .shp_dac    (shp_dac),
  .rsv_flag   (rsv_flag)
);

// File: tb/dds_core_bench.sv
module dds_core_bench;
  localparam real   PI    = 3.14159265358979;
  localparam time   TCLK  = 8ns;
  localparam int    FILL  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_reset;
  logic        freeze;
  logic        dac_pd;
  logic        msb_out_en;
  logic        tri_mode;
  logic        div2;
  logic [27:0] ftw;
  logic [11:0] phase_ofs;
  logic [9:0]  dac_word;
  logic        sq_out;
  logic        rsv_flag;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  longint k_run   = 0;
  bit     half_m  = 1'b0;
  bit     prev_m  = 1'b0;
  real    e_dac   = 512.0;
  bit     e_sine  = 1'b0;
  bit     e_sq    = 1'b0;
  bit     e_rsv   = 1'b0;

  always #(TCLK/2) clk = ~clk;

  dds_core u_dds_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_reset (core_reset),
    .freeze     (freeze),
    .dac_pd     (dac_pd),
    .msb_out_en (msb_out_en),
    .tri_mode   (tri_mode),
    .div2       (div2),
    .ftw        (ftw),
    .phase_ofs  (phase_ofs),
    .dac_word   (dac_word),
    .sq_out     (sq_out),
    .rsv_flag   (rsv_flag)
  );

  function automatic real sine_ref(input logic [27:0] ph);
    real s;
    s = $sin(2.0 * PI * (real'(int'(ph >> 18)) + 0.5) / 1024.0);
    return (s >= 0.0) ? 512.0 + 511.0 * s : 511.0 + 511.0 * s;
  endfunction

  function automatic int ramp_ref(input logic [27:0] ph);
    int t;
    t = int'(ph >> 17);
    return (t < 1024) ? t : 2047 - t;
  endfunction

  task automatic check(input string tag, input int act, input real exp, input real tol);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0.2f", tag, act, exp);
    end
  endtask

  task automatic tick(input string seg);
    longint      n;
    logic [27:0] ph;
    bit          m;
    string       tg;
    string       sqt;
    @(posedge clk);
    e_rsv = msb_out_en && tri_mode;
    if (core_reset) begin
      k_run = 0; half_m = 0; prev_m = 0;
      e_dac = 512.0; e_sq = 0; e_sine = 0;
    end else if (!freeze) begin
      k_run++;
      if (k_run >= FILL) begin
        n  = k_run - 7;
        ph = 28'((n * longint'(ftw) + (longint'(phase_ofs) << 16)) & 64'h0FFF_FFFF);
        m  = ph[27];
        if (m && !prev_m) half_m = ~half_m;
        prev_m = m;
        e_sine = 0;
        e_sq   = 0;
        if (msb_out_en && tri_mode) e_dac = 512.0;
        else if (msb_out_en) begin
          e_dac = sine_ref(ph); e_sine = 1;
          e_sq  = div2 ? m : half_m;
        end else if (tri_mode) e_dac = real'(ramp_ref(ph));
        else begin e_dac = sine_ref(ph); e_sine = 1; end
      end else begin
        e_dac = 512.0; e_sq = 0; e_sine = 0;
      end
    end
    #2ns;
    if (dac_pd)                        tg = "R6";
    else if (core_reset)               tg = "R2";
    else if (k_run < FILL)             tg = "R3";
    else if (freeze)                   tg = "R4";
    else if (msb_out_en && tri_mode)   tg = "R11";
    else if (tri_mode)                 tg = "R8";
    else                               tg = "R7";
    sqt = tg;
    if (!freeze && k_run >= FILL && msb_out_en && !tri_mode) sqt = div2 ? "R9" : "R10";
    check({seg, "/", tg, " dac_word"}, int'(dac_word), dac_pd ? 0.0 : e_dac,
          (e_sine && !dac_pd) ? 2.0 : 0.0);
    check({seg, "/", sqt, " sq_out"}, int'(sq_out), real'(e_sq), 0.0);
    check({seg, "/R11 rsv_flag"}, int'(rsv_flag), real'(e_rsv), 0.0);
  endtask

  task automatic run_seg(input string seg, input logic [27:0] f, input logic [11:0] o,
                         input bit en, input bit tr, input bit d2, input int cycles);
    core_reset = 1'b1;
    tick(seg);
    ftw = f; phase_ofs = o; msb_out_en = en; tri_mode = tr; div2 = d2;
    tick(seg);
    core_reset = 1'b0;
    for (int i = 0; i < cycles; i++) tick(seg);
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; core_reset = 1'b1; freeze = 1'b0; dac_pd = 1'b0;
    msb_out_en = 1'b0; tri_mode = 1'b0; div2 = 1'b1; ftw = '0; phase_ofs = '0;
    repeat (3) @(posedge clk);
    #2ns;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick("R2");

    // R1: ramp tracks accumulation, including wrap and zero step
    run_seg("R1", 28'h0123457, 12'h000, 0, 1, 1, 200);
    run_seg("R1", 28'hFFFFFFF, 12'h000, 0, 1, 1, 40);
    run_seg("R1", 28'h0000000, 12'h000, 0, 1, 1, 30);
    // R12: offset shifts sine and ramp
    run_seg("R12", 28'h00A3D71, 12'hA5C, 0, 0, 1, 200);
    run_seg("R12", 28'h0000000, 12'h400, 0, 1, 1, 20);
    // R9 / R10: square direct and halved
    run_seg("R9", 28'h0800000, 12'h000, 1, 0, 1, 150);
    run_seg("R10", 28'h0800000, 12'h000, 1, 0, 0, 150);
    run_seg("R10", 28'h0C00001, 12'h321, 1, 0, 0, 100);
    // R11: reserved combination
    run_seg("R11", 28'h0123456, 12'h000, 1, 1, 1, 30);
    // R4 / R5: freeze, change shape while frozen, resume
    run_seg("R4", 28'h0456789, 12'h000, 0, 1, 1, 40);
    freeze = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (i == 8) begin tri_mode = 1'b0; msb_out_en = 1'b1; div2 = 1'b0; end
      tick("R4");
    end
    freeze = 1'b0;
    for (int i = 0; i < 60; i++) tick("R5");
    // R6: power-down and recovery mid-run
    dac_pd = 1'b1;
    for (int i = 0; i < 10; i++) tick("R6");
    dac_pd = 1'b0;
    for (int i = 0; i < 10; i++) tick("R6");
    // R2 / R3: restart in the middle of a waveform
    core_reset = 1'b1;
    for (int i = 0; i < 2; i++) tick("R2");
    core_reset = 1'b0;
    for (int i = 0; i < 20; i++) tick("R3");
    // R3: freeze during pipeline fill
    core_reset = 1'b1; tick("R3");
    core_reset = 1'b0;
    for (int i = 0; i < 4; i++) tick("R3");
    freeze = 1'b1;
    for (int i = 0; i < 5; i++) tick("R3");
    freeze = 1'b0;
    for (int i = 0; i < 10; i++) tick("R3");

    // random segments
    for (int s = 0; s < 25; s++) begin
      run_seg("rnd", 28'($urandom()), 12'($urandom()), 1'($urandom()), 1'($urandom()),
              1'($urandom()), 4);
      for (int i = 0; i < 110; i++) begin
        if ($urandom_range(15) == 0) freeze = ~freeze;
        if ($urandom_range(31) == 0) begin
          msb_out_en = 1'($urandom()); tri_mode = 1'($urandom()); div2 = 1'($urandom());
        end
        if ($urandom_range(63) == 0) dac_pd = ~dac_pd;
        tick("rnd");
      end
      freeze = 1'b0; dac_pd = 1'b0;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule